// File: doc/BRIEF.md
# Banked Register File with Address Decoder

This block holds a small set of configuration registers on a single-clock access port. The port carries an 8-bit address, 8-bit write data and separate read and write strobes. Each register is placed at one in-bank address and is tied either to bank 0, to bank 1, or to both banks. A single bank bit decides which bank-specific registers are visible. That bit lives inside an ordinary register at in-bank address F7h, which is present in both banks. Software therefore switches banks with a plain write, and it can always reach the switch.

A per-register decoder compares the address and the bank bit and raises one select line per register. A register's storage is written only when its select and the write strobe are both high. A register's contents reach the read path only when its select and the read strobe are both high. Each register has its own power-on value and its own mask of writable bits. Bits outside the mask always hold the power-on value.

The reset input is active low. It clears the block asynchronously, and its release is synchronised to the clock. Read data and the read-valid flag are registered.

Top module: `banked_regfile`

## Requirements
- R1: While reset is held, and afterwards until the first write, every register reads its own power-on value: F7h→00h, 6Ch–6Fh→00h, F0h→00h, bank-0 F8h→40h, bank-1 F8h→81h, bank-1 D0h→00h. After reset the bank bit is 0.
- R2: A write stores `(wdata & mask) | (por & ~mask)`. The masks are FFh for 6Ch, 6Dh, 6Eh, F0h, bank-1 F8h and D0h; 3Fh for 6Fh; 0Fh for bank-0 F8h; 10h for F7h. For example, writing FFh to bank-0 F8h reads back as 4Fh.
- R3: Registers mapped to both banks (F7h, 6Ch–6Fh, F0h) respond at their address whatever the bank bit is.
- R4: A bank-specific register responds only when the bank bit matches its bank. Bank-0 F8h and bank-1 F8h are separate storage. Reads and writes of D0h in bank 0 have no effect.
- R5: Bit 4 of the register at F7h is the bank bit (1 = bank 1). A write there takes effect on the next access, and the other bits of that register read back as 0.
- R6: `rdata` and `rvalid` are updated one cycle after a cycle with `rd_en` high. An unmapped address, or a cycle without `rd_en`, gives `rdata` = 00h with `rvalid` = 0. A read and write to the same register in the same cycle returns the old contents.
- R7: A write to any address that differs from a register's address in one bit leaves that register unchanged.
- R8: At most one register select is active in any cycle.
- R9: Reset assertion clears the outputs at once. After `rst_n` rises, writes at the first two clock edges are ignored, and the write at the third edge is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| addr | input | 8 | In-bank register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data, 00h when nothing is selected |
| rvalid | output | 1 | High one cycle after a read that hit a register |

## Verification
All-ones and all-zeros writes, with a 00h access to F0h placed between them, catch data-path bits stuck at one value. Reading back the masked registers after an FFh write shows whether the write masks are applied. Each neighbour of 6Dh that differs in one address bit is written with 00h before 6Dh is read back, which exposes any decoder term that also matches a neighbouring address. Switching the bank back and forth around F8h and D0h separates mirrored registers from bank-specific ones, and reading F7h shows that only the bank bit is stored.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int ADDR_W       = 8;
  localparam int DATA_W       = 8;
  localparam int NUM_REGS     = 9;
  localparam int BANK_REG_IDX = 0;
  localparam int BANK_SEL_BIT = 4;

  typedef enum logic [1:0] {
    MAP_B0   = 2'd0,
    MAP_B1   = 2'd1,
    MAP_BOTH = 2'd2
  } map_e;

  typedef struct packed {
    map_e              mode;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] por;
    logic [DATA_W-1:0] wmask;
  } reg_desc_t;

  // Register map: index 0 must stay the bank-select register.
  function automatic reg_desc_t reg_desc(input int idx);
    reg_desc_t d;
    case (idx)
      0:       d = '{MAP_BOTH, 8'hF7, 8'h00, 8'h10};
      1:       d = '{MAP_BOTH, 8'h6C, 8'h00, 8'hFF};
      2:       d = '{MAP_BOTH, 8'h6D, 8'h00, 8'hFF};
      3:       d = '{MAP_BOTH, 8'h6E, 8'h00, 8'hFF};
      4:       d = '{MAP_BOTH, 8'h6F, 8'h00, 8'h3F};
      5:       d = '{MAP_B0,   8'hF8, 8'h40, 8'h0F};
      6:       d = '{MAP_B1,   8'hF8, 8'h81, 8'hFF};
      7:       d = '{MAP_BOTH, 8'hF0, 8'h00, 8'hFF};
      default: d = '{MAP_B1,   8'hD0, 8'h00, 8'hFF};
    endcase
    return d;
  endfunction
endpackage

// File: rtl/rb_rst_sync.sv
module rb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain <= '0;
    else           chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain[STAGES-1];
endmodule

// File: rtl/rb_decode.sv
module rb_decode
  import rb_pkg::*;
#(
  parameter int N = NUM_REGS
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              bank,
  output logic [N-1:0]      hit
);
  for (genvar g = 0; g < N; g++) begin : g_dec
    localparam reg_desc_t D = reg_desc(g);
    logic bank_ok;
    if (D.mode == MAP_BOTH) begin : g_both
      assign bank_ok = 1'b1;
    end else if (D.mode == MAP_B1) begin : g_b1
      assign bank_ok = bank;
    end else begin : g_b0
      assign bank_ok = ~bank;
    end
    assign hit[g] = (addr == D.addr) && bank_ok;
  end
endmodule

// File: rtl/rb_cell.sv
module rb_cell
  import rb_pkg::*;
#(
  parameter logic [DATA_W-1:0] POR  = '0,
  parameter logic [DATA_W-1:0] MASK = '1
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam logic [DATA_W-1:0] FIXED = POR & ~MASK;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)  q <= POR;
    else if (we)  q <= (wdata & MASK) | FIXED;
  end
endmodule

// File: rtl/rb_rdmux.sv
module rb_rdmux
  import rb_pkg::*;
#(
  parameter int N = NUM_REGS
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [N-1:0]      rd_gate,
  input  logic [DATA_W-1:0] q [N],
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] mux;

  always_comb begin
    mux = '0;
    for (int i = 0; i < N; i++) begin
      mux = mux | (q[i] & {DATA_W{rd_gate[i]}});
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= mux;
      rvalid <= |rd_gate;
    end
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int N = NUM_REGS;

  logic              arst_n;
  logic [N-1:0]      hit;
  logic [N-1:0]      wr_gate;
  logic [N-1:0]      rd_gate;
  logic [DATA_W-1:0] q [N];
  logic              bank;

  rb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(arst_n)
  );

  assign bank = q[BANK_REG_IDX][BANK_SEL_BIT];

  rb_decode #(.N(N)) u_dec (.addr(addr), .bank(bank), .hit(hit));

  assign wr_gate = hit & {N{wr_en}};
  assign rd_gate = hit & {N{rd_en}};

  for (genvar g = 0; g < N; g++) begin : g_reg
    localparam reg_desc_t D = reg_desc(g);
    rb_cell #(.POR(D.por), .MASK(D.wmask)) u_cell (
      .clk(clk), .arst_n(arst_n), .we(wr_gate[g]),
      .wdata(wdata), .q(q[g])
    );
  end

  rb_rdmux #(.N(N)) u_rd (
    .clk(clk), .arst_n(arst_n), .rd_gate(rd_gate), .q(q),
    .rdata(rdata), .rvalid(rvalid)
  );
endmodule

// File: rtl/rb_chk.sv
module rb_chk
  import rb_pkg::*;
#(
  parameter int N = NUM_REGS
) (
  input logic              clk,
  input logic              arst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              wr_en,
  input logic              rd_en,
  input logic [N-1:0]      hit,
  input logic              bank,
  input logic [DATA_W-1:0] rdata,
  input logic              rvalid
);
  // R8
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0(hit));

  // R6
  idle_out_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !rd_en |=> (!rvalid && rdata == '0));

  // R6
  hit_valid_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (rd_en && |hit) |=> rvalid);

  // R5
  bank_load_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (wr_en && addr == 8'hF7) |=> bank == $past(wdata[BANK_SEL_BIT]));

  // R5
  bank_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !(wr_en && addr == 8'hF7) |=> $stable(bank));

  // R3
  mirror_hit_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (addr == 8'h6C) |-> $countones(hit) == 1);
endmodule

bind banked_regfile rb_chk #(.N(rb_pkg::NUM_REGS)) u_chk (
  .clk(clk), .arst_n(arst_n), .addr(addr), .wdata(wdata),
  .wr_en(wr_en), .rd_en(rd_en), .hit(hit), .bank(bank),
  .rdata(rdata), .rvalid(rvalid)
);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic       rvalid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  banked_regfile u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .rvalid(rvalid)
  );

  // {op(2) 0=write 1=read, req(4), addr(8), data(8), valid(1)}
  localparam int NVEC = 38;
  localparam logic [22:0] VEC [NVEC] = '{
    {2'd0,4'd2,8'h6C,8'hFF,1'b0}, {2'd0,4'd2,8'hF0,8'h00,1'b0},
    {2'd1,4'd2,8'hF0,8'h00,1'b1}, {2'd1,4'd2,8'h6C,8'hFF,1'b1},
    {2'd0,4'd2,8'h6C,8'h00,1'b0}, {2'd1,4'd2,8'h6C,8'h00,1'b1},
    {2'd0,4'd2,8'h6F,8'hFF,1'b0}, {2'd1,4'd2,8'h6F,8'h3F,1'b1},
    {2'd0,4'd2,8'hF8,8'hFF,1'b0}, {2'd1,4'd2,8'hF8,8'h4F,1'b1},
    {2'd0,4'd7,8'h6D,8'hFF,1'b0}, {2'd0,4'd7,8'hED,8'h00,1'b0},
    {2'd0,4'd7,8'h2D,8'h00,1'b0}, {2'd0,4'd7,8'h4D,8'h00,1'b0},
    {2'd0,4'd7,8'h7D,8'h00,1'b0}, {2'd0,4'd7,8'h65,8'h00,1'b0},
    {2'd0,4'd7,8'h69,8'h00,1'b0}, {2'd0,4'd7,8'h6F,8'h00,1'b0},
    {2'd0,4'd7,8'h6C,8'h00,1'b0}, {2'd1,4'd7,8'h6D,8'hFF,1'b1},
    {2'd0,4'd5,8'hF7,8'h10,1'b0}, {2'd1,4'd5,8'hF7,8'h10,1'b1},
    {2'd1,4'd3,8'h6D,8'hFF,1'b1}, {2'd1,4'd4,8'hF8,8'h81,1'b1},
    {2'd0,4'd4,8'hF8,8'h00,1'b0}, {2'd1,4'd4,8'hF8,8'h00,1'b1},
    {2'd0,4'd4,8'hD0,8'h5A,1'b0}, {2'd1,4'd4,8'hD0,8'h5A,1'b1},
    {2'd0,4'd5,8'hF7,8'h00,1'b0}, {2'd1,4'd4,8'hF8,8'h4F,1'b1},
    {2'd1,4'd4,8'hD0,8'h00,1'b0}, {2'd0,4'd4,8'hD0,8'h33,1'b0},
    {2'd0,4'd5,8'hF7,8'h10,1'b0}, {2'd1,4'd4,8'hD0,8'h5A,1'b1},
    {2'd0,4'd5,8'hF7,8'hEF,1'b0}, {2'd1,4'd5,8'hF7,8'h00,1'b1},
    {2'd1,4'd3,8'h6D,8'hFF,1'b1}, {2'd1,4'd6,8'h12,8'h00,1'b0}
  };

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] got_d, input logic got_v,
                       input logic [7:0] exp_d, input logic exp_v);
    checks++;
    if (got_d !== exp_d || got_v !== exp_v) begin
      failures++;
      $display("FAIL %s: rdata=%h rvalid=%b expected rdata=%h rvalid=%b",
               req, got_d, got_v, exp_d, exp_v);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input string req, input logic [7:0] a,
                       input logic [7:0] exp_d, input logic exp_v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rdata, rvalid, exp_d, exp_v);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 / R9: outputs cleared while reset is held
    repeat (3) @(negedge clk);
    check("R9", rdata, rvalid, 8'h00, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: power-on values, bank 0 visible
    do_rd("R1", 8'hF7, 8'h00, 1'b1);
    do_rd("R1", 8'h6C, 8'h00, 1'b1);
    do_rd("R1", 8'h6D, 8'h00, 1'b1);
    do_rd("R1", 8'h6E, 8'h00, 1'b1);
    do_rd("R1", 8'h6F, 8'h00, 1'b1);
    do_rd("R1", 8'hF0, 8'h00, 1'b1);
    do_rd("R1", 8'hF8, 8'h40, 1'b1);

    // Main vector walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][22:21] == 2'd0) do_wr(VEC[i][16:9], VEC[i][8:1]);
      else do_rd(req_name(VEC[i][20:17]), VEC[i][16:9], VEC[i][8:1], VEC[i][0]);
    end
    do_wr(8'hF7, 8'h00);

    // R6: no read strobe -> outputs idle
    @(negedge clk); addr = 8'h6D;
    @(negedge clk);
    check("R6", rdata, rvalid, 8'h00, 1'b0);

    // R6: read and write same register in one cycle returns old data
    @(negedge clk);
    addr = 8'h6E; wdata = 8'h77; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R6", rdata, rvalid, 8'h00, 1'b1);
    do_rd("R6", 8'h6E, 8'h77, 1'b1);

    // R9: asynchronous reset mid-run clears outputs at once
    @(negedge clk);
    addr = 8'h6D; rd_en = 1'b1;
    @(posedge clk); #1;
    rst_n = 1'b0; #0.5;
    check("R9", rdata, rvalid, 8'h00, 1'b0);
    @(negedge clk); rd_en = 1'b0;
    repeat (2) @(negedge clk);

    // R9: writes at the first two edges after release are ignored
    rst_n = 1'b1;
    addr = 8'h6C; wdata = 8'hAA; wr_en = 1'b1;
    repeat (2) @(negedge clk);
    wr_en = 1'b0;
    do_rd("R9", 8'h6C, 8'h00, 1'b1);

    // R9: write at the third edge after release is stored
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    addr = 8'h6C; wdata = 8'h55; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    do_rd("R9", 8'h6C, 8'h55, 1'b1);

    // R1: reset restored contents and bank 0
    do_rd("R1", 8'h6D, 8'h00, 1'b1);
    do_rd("R1", 8'hF8, 8'h40, 1'b1);
    do_wr(8'hF7, 8'h10);
    do_rd("R1", 8'hF8, 8'h81, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule